// File: doc/BRIEF.md
# Threshold-Start Transmit FIFO Controller

This block buffers transmit words coming from a DMA engine and decides when the MAC transmitter may start on a frame. Each incoming word has an end-of-frame marker. The block keeps track of how many words it holds and how many complete frames it holds. Transmission of the frame at the head of the buffer begins when one of two things happens first:

- the fill level reaches a threshold chosen by a 3-bit selector, or
- at least one complete frame has been stored.

A store-and-forward control bit turns the threshold rule off. In that mode only a complete frame can start transmission.

Once a frame is being sent, the transmitter pulls one word on every cycle it asserts its ready input. If the transmitter asks for data while the buffer is empty partway through a frame, the block raises a one-cycle underflow pulse and aborts the frame. It then silently throws away the rest of that frame, up to and including its end-of-frame word, and goes back to idle.

Top module: `tx_thresh_fifo`

## Requirements
- R1: After reset the outputs are as follows: `txValid`, `txBusy` and `txUnderflow` are 0, and `pushReady` is 1.
- R2: With `storeFwd`=0, `thrSel` picks the start threshold in words: 0→64, 1→128, 2→192, 3→256, 4→40, 5→32, 6→24, 7→16. `txBusy` rises one cycle after the clock edge that brings the level up to the threshold. While the level is below the threshold and no complete frame is held, `txBusy` stays 0.
- R3: When a word with `pushLast`=1 is accepted while idle, `txBusy` rises one cycle later, whatever the threshold.
- R4: With `storeFwd`=1, reaching the threshold does not start transmission; only a stored end-of-frame word does.
- R5: While `txBusy`=1, each cycle with `txValid` and `txReady` high pops one word. Words come out in push order, and `txLast` marks the end-of-frame word. After that word is popped, `txBusy` returns to 0.
- R6: If `txReady`=1 while sending and the buffer is empty, `txValid` is 0 in that cycle and `txUnderflow` is high for exactly the next cycle. `txBusy` is 0 during that pulse.
- R7: After an underflow, the remaining words of the aborted frame, up to and including the end-of-frame word, are discarded and never shown with `txValid`=1. A frame pushed after them is delivered intact.
- R8: `pushReady` is 0 when DEPTH words are stored, and a push offered at that time is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | DMA offers a word |
| pushData | input | DATA_W | Offered word |
| pushLast | input | 1 | Offered word ends its frame |
| pushReady | output | 1 | Buffer can accept a word |
| thrSel | input | 3 | Start-threshold selector |
| storeFwd | input | 1 | 1 = start only on a complete frame |
| txReady | input | 1 | Transmitter takes a word this cycle |
| txValid | output | 1 | Head word is presented for transmission |
| txData | output | DATA_W | Head word |
| txLast | output | 1 | Head word ends its frame |
| txBusy | output | 1 | A frame is being sent |
| txUnderflow | output | 1 | One-cycle pulse: frame aborted on empty buffer |

## Verification
A push is taken on a rising edge, and the level and frame count change on that same edge. The start decision is registered, so `txBusy` and `txValid` are due one edge later. The bench checks that they are still low just after the accepting edge and high after the next one.

Popped data is visible in the same cycle as `txValid`. An underflow is detected on the edge after the empty cycle with `txReady` high, so the pulse is checked one cycle later and checked to be gone one cycle after that.

All inputs are driven, and all outputs sampled, on falling edges, so each expected value lines up with a known count of rising edges.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_FLUSH = 2'd2
  } txState_e;
endpackage

// File: rtl/txf_datapath.sv
module txf_datapath
  import txf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  output logic              full,
  output logic              empty,
  output logic [LVL_W-1:0]  level,
  output logic              frameAny,
  output logic [DATA_W-1:0] headData,
  output logic              headLast
);
  logic [DATA_W:0]   mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [LVL_W-1:0]  frameCnt;
  logic              popEof;

  assign full     = (level == LVL_W'(DEPTH));
  assign empty    = (level == '0);
  assign headData = mem[rdPtr][DATA_W-1:0];
  assign headLast = mem[rdPtr][DATA_W];
  assign frameAny = (frameCnt != '0);
  assign popEof   = strobe.pop && headLast;

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= {wrLast, wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      level    <= '0;
      frameCnt <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      case ({strobe.push && wrLast, popEof})
        2'b10:   frameCnt <= frameCnt + 1'b1;
        2'b01:   frameCnt <= frameCnt - 1'b1;
        default: frameCnt <= frameCnt;
      endcase
    end
  end

  // R8: the control never writes into a full buffer
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> !full);
  // R6: the control never reads from an empty buffer
  p_no_underread_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !empty);
  // R8: the level never exceeds the depth
  p_level_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));
  // R3: stored frames never outnumber stored words
  p_frames_le_words_r3: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt <= level);
endmodule

// File: rtl/txf_control.sv
module txf_control
  import txf_pkg::*;
#(
  parameter int LVL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic [2:0]       thrSel,
  input  logic             storeFwd,
  input  logic             txReady,
  input  logic             full,
  input  logic             empty,
  input  logic [LVL_W-1:0] level,
  input  logic             frameAny,
  input  logic             headLast,
  output fifoStrobe_t      strobe,
  output logic             pushReady,
  output logic             txValid,
  output logic             txBusy,
  output logic             txUnderflow
);
  txState_e         state, stateNx;
  logic [LVL_W-1:0] thrWords;
  logic             startOk, uflowNow;

  // upper half of the code space counts down in 8-word steps from 40
  always_comb begin
    if (!thrSel[2]) thrWords = LVL_W'((32'(thrSel[1:0]) + 32'd1) * 32'd64);
    else            thrWords = LVL_W'(32'd40 - 32'(thrSel[1:0]) * 32'd8);
  end

  assign startOk   = !empty && (frameAny || (!storeFwd && level >= thrWords));
  assign pushReady = !full;
  assign txValid   = (state == ST_SEND) && !empty;
  assign txBusy    = (state == ST_SEND);
  assign uflowNow  = (state == ST_SEND) && txReady && empty;

  always_comb begin
    stateNx     = state;
    strobe.push = pushValid && !full;
    strobe.pop  = 1'b0;
    case (state)
      ST_IDLE:  if (startOk) stateNx = ST_SEND;
      ST_SEND: begin
        if (txReady && !empty) begin
          strobe.pop = 1'b1;
          if (headLast) stateNx = ST_IDLE;
        end else if (uflowNow) begin
          stateNx = ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        if (!empty) begin
          strobe.pop = 1'b1;
          if (headLast) stateNx = ST_IDLE;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      txUnderflow <= 1'b0;
    end else begin
      state       <= stateNx;
      txUnderflow <= uflowNow;
    end
  end

  // R4: in store-and-forward mode no start without a stored frame
  p_sf_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && storeFwd && !frameAny) |=> (state != ST_SEND));
  // R6: the underflow flag is a single-cycle pulse
  p_uflow_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    txUnderflow |=> !txUnderflow);
  // R7: an underflow always leads into discarding
  p_uflow_flush_r7: assert property (@(posedge clk) disable iff (!rstN)
    txUnderflow |-> (state == ST_FLUSH));
  // R5: popping the end-of-frame word while sending ends the frame
  p_eof_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && strobe.pop && headLast) |=> (state == ST_IDLE));
endmodule

// File: rtl/tx_thresh_fifo.sv
module tx_thresh_fifo
  import txf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pushLast,
  output logic              pushReady,
  input  logic [2:0]        thrSel,
  input  logic              storeFwd,
  input  logic              txReady,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  output logic              txLast,
  output logic              txBusy,
  output logic              txUnderflow
);
  fifoStrobe_t      strobe;
  logic             full, empty, frameAny;
  logic [LVL_W-1:0] level;

  txf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(pushData),
    .wrLast(pushLast), .full(full), .empty(empty), .level(level),
    .frameAny(frameAny), .headData(txData), .headLast(txLast)
  );

  txf_control #(.LVL_W(LVL_W)) u_ctl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .thrSel(thrSel),
    .storeFwd(storeFwd), .txReady(txReady), .full(full), .empty(empty),
    .level(level), .frameAny(frameAny), .headLast(txLast),
    .strobe(strobe), .pushReady(pushReady), .txValid(txValid),
    .txBusy(txBusy), .txUnderflow(txUnderflow)
  );
endmodule

// File: tb/sim_tx_thresh_fifo.sv
module sim_tx_thresh_fifo;
  localparam int DW = 32;
  localparam int DEPTH = 512;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pushValid = 1'b0, pushLast = 1'b0;
  logic [DW-1:0] pushData = '0;
  logic          pushReady;
  logic [2:0]    thrSel = 3'd0;
  logic          storeFwd = 1'b0, txReady = 1'b0;
  logic          txValid, txLast, txBusy, txUnderflow;
  logic [DW-1:0] txData;
  int            compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  tx_thresh_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .pushLast(pushLast), .pushReady(pushReady), .thrSel(thrSel),
    .storeFwd(storeFwd), .txReady(txReady), .txValid(txValid),
    .txData(txData), .txLast(txLast), .txBusy(txBusy),
    .txUnderflow(txUnderflow)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // one word accepted on the next rising edge; returns at the falling edge after it
  task automatic pushWord(input logic [DW-1:0] d, input logic l);
    pushValid = 1'b1; pushData = d; pushLast = l;
    @(negedge clk);
    pushValid = 1'b0; pushLast = 1'b0;
  endtask

  task automatic pushRun(input int n, input logic [DW-1:0] base, input logic lastOnEnd);
    for (int i = 0; i < n; i++) pushWord(base + DW'(i), lastOnEnd && (i == n - 1));
  endtask

  task automatic drain(input string tag, input int n, input logic [DW-1:0] base);
    txReady = 1'b1;
    for (int i = 0; i < n; i++) begin
      check({tag, " valid"}, {31'd0, txValid}, 32'd1);
      check({tag, " data"}, txData, base + DW'(i));
      check({tag, " last"}, {31'd0, txLast}, {31'd0, i == n - 1});
      @(negedge clk);
    end
    txReady = 1'b0;
    check({tag, " idle after frame"}, {31'd0, txBusy}, 32'd0);
  endtask

  task automatic testReset();
    check("R1 txValid", {31'd0, txValid}, 32'd0);
    check("R1 txBusy", {31'd0, txBusy}, 32'd0);
    check("R1 txUnderflow", {31'd0, txUnderflow}, 32'd0);
    check("R1 pushReady", {31'd0, pushReady}, 32'd1);
  endtask

  task automatic testThreshold(input logic [2:0] sel, input int words);
    thrSel = sel; storeFwd = 1'b0;
    pushRun(words - 1, 32'h1000, 1'b0);
    @(negedge clk);
    check("R2 below threshold idle", {31'd0, txBusy}, 32'd0);
    pushWord(32'h1000 + DW'(words - 1), 1'b0);
    check("R2 no start on reaching edge", {31'd0, txBusy}, 32'd0);
    @(negedge clk);
    check("R2 start after threshold", {31'd0, txBusy}, 32'd1);
    pushWord(32'h1000 + DW'(words), 1'b1);
    drain("R5 threshold frame", words + 1, 32'h1000);
  endtask

  task automatic testFrameStart();
    thrSel = 3'd0; storeFwd = 1'b0;
    pushRun(3, 32'h2000, 1'b1);
    check("R3 not yet busy", {31'd0, txBusy}, 32'd0);
    @(negedge clk);
    check("R3 complete frame starts", {31'd0, txBusy}, 32'd1);
    drain("R5 short frame", 3, 32'h2000);
  endtask

  task automatic testStoreFwd();
    thrSel = 3'd7; storeFwd = 1'b1;
    pushRun(20, 32'h3000, 1'b0);
    @(negedge clk); @(negedge clk);
    check("R4 threshold ignored", {31'd0, txBusy}, 32'd0);
    pushWord(32'h3000 + 32'd20, 1'b1);
    @(negedge clk);
    check("R4 start on frame end", {31'd0, txBusy}, 32'd1);
    drain("R4 sf frame", 21, 32'h3000);
    storeFwd = 1'b0;
  endtask

  task automatic testUnderflow();
    thrSel = 3'd7; storeFwd = 1'b0;
    pushRun(16, 32'h4000, 1'b0);
    @(negedge clk);
    check("R6 started", {31'd0, txBusy}, 32'd1);
    txReady = 1'b1;
    for (int i = 0; i < 16; i++) begin
      check("R5 uflow frame data", txData, 32'h4000 + DW'(i));
      @(negedge clk);
    end
    check("R6 txValid low when empty", {31'd0, txValid}, 32'd0);
    check("R6 no pulse yet", {31'd0, txUnderflow}, 32'd0);
    @(negedge clk);
    txReady = 1'b0;
    check("R6 underflow pulse", {31'd0, txUnderflow}, 32'd1);
    check("R6 busy low during pulse", {31'd0, txBusy}, 32'd0);
    @(negedge clk);
    check("R6 pulse one cycle", {31'd0, txUnderflow}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      pushWord(32'h5000 + DW'(i), i == 3);
      check("R7 flushed word hidden", {31'd0, txValid}, 32'd0);
    end
    pushRun(2, 32'h6000, 1'b1);
    check("R7 hidden before start", {31'd0, txValid}, 32'd0);
    @(negedge clk);
    check("R7 next frame starts", {31'd0, txBusy}, 32'd1);
    drain("R7 next frame", 2, 32'h6000);
  endtask

  task automatic testFull();
    thrSel = 3'd3; storeFwd = 1'b1;
    pushRun(DEPTH, 32'h8000, 1'b1);
    check("R8 pushReady low when full", {31'd0, pushReady}, 32'd0);
    pushWord(32'hDEAD, 1'b1);
    check("R8 sending", {31'd0, txBusy}, 32'd1);
    drain("R8 full frame", DEPTH, 32'h8000);
    @(negedge clk);
    check("R8 extra push not stored", {31'd0, txValid | txBusy}, 32'd0);
    storeFwd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testThreshold(3'd7, 16);
    testThreshold(3'd6, 24);
    testThreshold(3'd4, 40);
    testThreshold(3'd0, 64);
    testThreshold(3'd3, 256);
    testFrameStart();
    testStoreFwd();
    testUnderflow();
    testFull();
    finishRun();
  end
endmodule